// File: doc/BRIEF.md
# Quadrature Incremental Position Counter

This block turns the two phase-shifted square waves of an incremental position encoder into an absolute position count. Both encoder phases go through two-flop synchronizers. The decoder then compares each synchronized sample of the phase pair with the one before it. A change on exactly one phase is one increment of travel. The order in which the phases move gives the direction. The block counts on every edge of both phases, so one full encoder cycle adds or removes four counts. The result is a 16-bit position register that follows the shaft or slide as it moves, and that software can overwrite at any time, for example after a homing move.

A third encoder line marks the reference position once per revolution or stroke. It is synchronized the same way and turned into a one-cycle interrupt request when it makes a qualifying edge. A parameter selects rising, falling or both edges. If both phases change between two synchronized samples, the move cannot be resolved. In that case the count is left alone and a sticky error flag is raised. It stays raised until software clears it.

Top module: `qdec_pos_counter`

## Requirements
- R1: After reset, `pos_o` is 0, `dir_o` is 0, `err_o` is 0 and `idx_irq_o` is 0.
- R2: Phase state is written {A,B}. The forward order is 00, 10, 11, 01, then back to 00, so A leads B. Each single-phase change in this order adds one to `pos_o` and sets `dir_o` to 1.
- R3: Each single-phase change in the reverse order (00, 01, 11, 10) subtracts one from `pos_o` and sets `dir_o` to 0.
- R4: The position wraps modulo 2^16: one step up from 16'hFFFF gives 0, and one step down from 0 gives 16'hFFFF.
- R5: If A and B both change between two synchronized samples, `pos_o` and `dir_o` keep their values and `err_o` goes to 1. `err_o` stays 1 until a cycle with `err_clr_i` high. If a new clash arrives in the same cycle as the clear, the flag stays at 1.
- R6: A cycle with `wr_en_i` high loads `wr_data_i` into `pos_o` on the next clock edge. If a count step falls in the same cycle, the write wins and the step is dropped.
- R7: With IDX_EDGE=0 (the default), a rising edge on `index_i` gives exactly one cycle of `idx_irq_o` and a falling edge gives none. IDX_EDGE=1 selects falling edges and 2 selects both.
- R8: A change on `phase_a_i`, `phase_b_i` or `index_i` that is stable before a rising clock edge shows at the outputs after the third rising edge, and not after the second.
- R9: Input levels present when reset is released give no count, no error and no interrupt. Only later changes are decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| phase_a_i | input | 1 | Encoder phase A, asynchronous |
| phase_b_i | input | 1 | Encoder phase B, asynchronous |
| index_i | input | 1 | Encoder reference mark, asynchronous |
| wr_en_i | input | 1 | Load `wr_data_i` into the position |
| wr_data_i | input | 16 | New position value |
| err_clr_i | input | 1 | Clear the sticky error flag |
| pos_o | output | 16 | Current position count |
| dir_o | output | 1 | Direction of the last valid step, 1 = forward |
| err_o | output | 1 | Sticky flag: both phases changed in one sample |
| idx_irq_o | output | 1 | One-cycle interrupt request on a qualifying index edge |

## Verification
The bench walks the encoder forward and backward across zero and across 16'hFFFF. A decoder with a swapped direction rule, or one that counts only on one phase, would end far from the expected count. It times one phase change against the clock. A design with one synchronizer stage too few or too many would update a cycle early or late. It lines up a write with a count step, and a clash with an error clear, in the same cycle. A design with the wrong priority would leave the position one off or lose the error. It also starts the block with both phases and the index held high through reset. A design without the start-up guard would count, flag an error or raise an interrupt that no real movement caused.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  // Index edge selection codes
  localparam int unsigned IDX_RISE = 0;
  localparam int unsigned IDX_FALL = 1;
  localparam int unsigned IDX_BOTH = 2;

  // One decoded sample of the phase pair
  typedef struct packed {
    logic valid;  // exactly one phase moved
    logic up;     // direction of that move
    logic clash;  // both phases moved, not resolvable
  } qdec_step_t;

endpackage

// File: rtl/qdec_rst_sync.sv
module qdec_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      always_comb stage_d = d_i;
    end else begin : g_rest
      always_comb stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= stage_d;
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/qdec_decode.sv
module qdec_decode
  import qdec_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a_i,
  input  logic       b_i,
  output logic       primed_o,
  output qdec_step_t step_o
);

  // Samples become meaningful once the synchronizers and the previous
  // sample register all hold post-reset data.
  localparam int unsigned WARM_LAST = SYNC_STAGES + 1;
  localparam int unsigned WARM_W    = $clog2(WARM_LAST + 1);

  logic [WARM_W-1:0] warm_q, warm_d;
  logic              prev_a_q, prev_b_q;
  logic              chg_a, chg_b;

  always_comb begin
    warm_d = warm_q;
    if (warm_q != WARM_W'(WARM_LAST)) begin
      warm_d = warm_q + 1'b1;
    end
  end

  assign primed_o = (warm_q == WARM_W'(WARM_LAST));

  always_comb begin
    chg_a        = a_i ^ prev_a_q;
    chg_b        = b_i ^ prev_b_q;
    step_o.valid = primed_o & (chg_a ^ chg_b);
    step_o.clash = primed_o & chg_a & chg_b;
    // Forward order 00,10,11,01: new A differs from old B on each forward move
    step_o.up    = a_i ^ prev_b_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q   <= '0;
      prev_a_q <= 1'b0;
      prev_b_q <= 1'b0;
    end else begin
      warm_q   <= warm_d;
      prev_a_q <= a_i;
      prev_b_q <= b_i;
    end
  end

endmodule

// File: rtl/qdec_index.sv
module qdec_index
  import qdec_pkg::*;
#(
  parameter int unsigned IDX_EDGE = IDX_RISE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic idx_i,
  input  logic primed_i,
  output logic irq_o
);

  logic prev_q;
  logic irq_q, irq_d;
  logic hit;

  if (IDX_EDGE == IDX_FALL) begin : g_fall
    assign hit = prev_q & ~idx_i;
  end else if (IDX_EDGE == IDX_BOTH) begin : g_both
    assign hit = prev_q ^ idx_i;
  end else begin : g_rise
    assign hit = ~prev_q & idx_i;
  end

  always_comb begin
    irq_d = primed_i & hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= idx_i;
      irq_q  <= irq_d;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/qdec_position.sv
module qdec_position
  import qdec_pkg::*;
#(
  parameter int unsigned POS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  qdec_step_t       step_i,
  input  logic             wr_en_i,
  input  logic [POS_W-1:0] wr_data_i,
  input  logic             err_clr_i,
  output logic [POS_W-1:0] pos_o,
  output logic             dir_o,
  output logic             err_o
);

  logic [POS_W-1:0] pos_q, pos_d;
  logic             dir_q, dir_d;
  logic             err_q, err_d;
  logic             pos_en;

  always_comb begin
    pos_en = wr_en_i | step_i.valid;
    pos_d  = pos_q;
    if (wr_en_i) begin
      pos_d = wr_data_i;
    end else if (step_i.valid) begin
      pos_d = step_i.up ? pos_q + 1'b1 : pos_q - 1'b1;
    end
  end

  always_comb begin
    dir_d = dir_q;
    if (step_i.valid) begin
      dir_d = step_i.up;
    end
  end

  always_comb begin
    err_d = err_q;
    if (step_i.clash) begin
      err_d = 1'b1;
    end else if (err_clr_i) begin
      err_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (pos_en) begin
      pos_q <= pos_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      dir_q <= dir_d;
      err_q <= err_d;
    end
  end

  assign pos_o = pos_q;
  assign dir_o = dir_q;
  assign err_o = err_q;

endmodule

// File: rtl/qdec_pos_counter.sv
module qdec_pos_counter
  import qdec_pkg::*;
#(
  parameter int unsigned POS_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned IDX_EDGE    = IDX_RISE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_a_i,
  input  logic             phase_b_i,
  input  logic             index_i,
  input  logic             wr_en_i,
  input  logic [POS_W-1:0] wr_data_i,
  input  logic             err_clr_i,
  output logic [POS_W-1:0] pos_o,
  output logic             dir_o,
  output logic             err_o,
  output logic             idx_irq_o
);

  localparam int unsigned N_IN = 3;

  logic            rst_int_n;
  logic [N_IN-1:0] raw_in;
  logic [N_IN-1:0] syn_in;
  logic            primed;
  qdec_step_t      step;

  qdec_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign raw_in = {index_i, phase_b_i, phase_a_i};

  qdec_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (raw_in),
    .q_o   (syn_in)
  );

  qdec_decode #(.SYNC_STAGES(SYNC_STAGES)) u_dec (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .a_i      (syn_in[0]),
    .b_i      (syn_in[1]),
    .primed_o (primed),
    .step_o   (step)
  );

  qdec_index #(.IDX_EDGE(IDX_EDGE)) u_idx (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .idx_i    (syn_in[2]),
    .primed_i (primed),
    .irq_o    (idx_irq_o)
  );

  qdec_position #(.POS_W(POS_W)) u_pos (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .step_i    (step),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .err_clr_i (err_clr_i),
    .pos_o     (pos_o),
    .dir_o     (dir_o),
    .err_o     (err_o)
  );

endmodule

// File: rtl/qdec_pos_counter_chk.sv
module qdec_pos_counter_chk #(
  parameter int unsigned POS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en_i,
  input logic [POS_W-1:0] wr_data_i,
  input logic             err_clr_i,
  input logic [POS_W-1:0] pos_o,
  input logic             dir_o,
  input logic             err_o,
  input logic             idx_irq_o
);

  // R6: a write lands on the next edge
  assert_write_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (pos_o == $past(wr_data_i)));

  // R2, R3, R4: without a write the position moves by at most one, modulo 2^16
  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> ((pos_o == $past(pos_o)) ||
                  (pos_o == POS_W'($past(pos_o) + 1'b1)) ||
                  (pos_o == POS_W'($past(pos_o) - 1'b1))));

  // R2: a forward step leaves the direction flag at 1
  assert_up_sets_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en_i) && pos_o == POS_W'($past(pos_o) + 1'b1)) |-> dir_o);

  // R3: a backward step leaves the direction flag at 0
  assert_down_clears_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en_i) && pos_o == POS_W'($past(pos_o) - 1'b1)) |-> !dir_o);

  // R5: the error flag is sticky while no clear is requested
  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !err_clr_i) |=> err_o);

  // R5: raising the error never comes with a count change
  assert_err_no_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> ((pos_o == $past(pos_o)) || $past(wr_en_i)));

endmodule

bind qdec_pos_counter qdec_pos_counter_chk #(.POS_W(POS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .err_clr_i (err_clr_i),
  .pos_o     (pos_o),
  .dir_o     (dir_o),
  .err_o     (err_o),
  .idx_irq_o (idx_irq_o)
);

// File: tb/sim_qdec_pos_counter.sv
`timescale 1ns/1ps
module sim_qdec_pos_counter;

  logic        clk;
  logic        rst_n;
  logic        phase_a_i, phase_b_i, index_i;
  logic        wr_en_i;
  logic [15:0] wr_data_i;
  logic        err_clr_i;
  logic [15:0] pos_o;
  logic        dir_o, err_o, idx_irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  int irq_cnt = 0;
  bit finished = 0;
  int ph = 0;  // index into forward order 00,10,11,01

  qdec_pos_counter u0 (
    .clk(clk), .rst_n(rst_n), .phase_a_i(phase_a_i), .phase_b_i(phase_b_i),
    .index_i(index_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .err_clr_i(err_clr_i), .pos_o(pos_o), .dir_o(dir_o), .err_o(err_o),
    .idx_irq_o(idx_irq_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) if (idx_irq_o) irq_cnt++;

  function automatic logic [1:0] gray(input int p);
    case (p & 3)
      0: gray = 2'b00;
      1: gray = 2'b10;
      2: gray = 2'b11;
      default: gray = 2'b01;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive_ph();
    {phase_a_i, phase_b_i} = gray(ph);
  endtask

  task automatic move(input bit up, input int n);
    for (int i = 0; i < n; i++) begin
      ph = up ? ph + 1 : ph + 3;
      drive_ph();
      cycles(5);
    end
  endtask

  task automatic do_reset(input logic [1:0] ab, input logic idx);
    rst_n = 1'b0;
    {phase_a_i, phase_b_i} = ab;
    index_i = idx;
    wr_en_i = 1'b0; wr_data_i = '0; err_clr_i = 1'b0;
    cycles(3);
    rst_n = 1'b1;
    cycles(10);
  endtask

  task automatic t_reset();
    ph = 0;
    do_reset(2'b00, 1'b0);
    chk("R1 pos", pos_o, 0);
    chk("R1 dir", dir_o, 0);
    chk("R1 err", err_o, 0);
    chk("R1 irq count", irq_cnt, 0);
  endtask

  task automatic t_latency();
    ph = 1; drive_ph();          // driven just after a falling edge
    @(negedge clk); @(negedge clk);
    chk("R8 no update after 2 edges", pos_o, 0);
    @(negedge clk);
    chk("R8 update after 3 edges", pos_o, 1);
    cycles(3);
  endtask

  task automatic t_count_up();
    move(1'b1, 7);
    chk("R2 forward 8 counts", pos_o, 8);
    chk("R2 dir forward", dir_o, 1);
  endtask

  task automatic t_count_down();
    move(1'b0, 3);
    chk("R3 backward count", pos_o, 5);
    chk("R3 dir backward", dir_o, 0);
    move(1'b0, 9);
    chk("R4 wrap below zero", pos_o, 16'hFFFC);
  endtask

  task automatic t_wrap_up();
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = 16'hFFFE;
    @(negedge clk); wr_en_i = 1'b0;
    chk("R6 write loads", pos_o, 16'hFFFE);
    move(1'b1, 3);
    chk("R4 wrap above max", pos_o, 16'h0001);
    chk("R2 dir after wrap", dir_o, 1);
  endtask

  task automatic t_clash();
    logic [15:0] p0;
    p0 = pos_o;
    ph = ph + 2; drive_ph();     // both phases flip together
    cycles(5);
    chk("R5 clash no count", pos_o, p0);
    chk("R5 clash sets err", err_o, 1);
    chk("R5 clash keeps dir", dir_o, 1);
    move(1'b0, 1);
    chk("R5 count resumes after clash", pos_o, 16'(p0 - 1));
    chk("R5 err sticky", err_o, 1);
    @(negedge clk); err_clr_i = 1'b1;
    @(negedge clk); err_clr_i = 1'b0;
    chk("R5 err cleared", err_o, 0);
  endtask

  task automatic t_clash_vs_clear();
    ph = ph + 2; drive_ph();     // clash reaches the decoder at the third edge
    @(negedge clk); @(negedge clk);
    err_clr_i = 1'b1;            // clear in the same cycle as the clash
    @(negedge clk);
    err_clr_i = 1'b0;
    cycles(2);
    chk("R5 set wins over clear", err_o, 1);
    @(negedge clk); err_clr_i = 1'b1;
    @(negedge clk); err_clr_i = 1'b0;
  endtask

  task automatic t_write_vs_count();
    ph = ph + 1; drive_ph();     // forward step lands on the third edge
    @(negedge clk); @(negedge clk);
    wr_en_i = 1'b1; wr_data_i = 16'h1234;
    @(negedge clk);
    wr_en_i = 1'b0;
    cycles(3);
    chk("R6 write wins over step", pos_o, 16'h1234);
  endtask

  task automatic t_index();
    int c0;
    c0 = irq_cnt;
    index_i = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R8 irq not early", idx_irq_o, 0);
    @(negedge clk);
    chk("R7 irq on rising edge", idx_irq_o, 1);
    @(negedge clk);
    chk("R7 irq lasts one cycle", idx_irq_o, 0);
    cycles(4);
    chk("R7 one pulse per rise", irq_cnt - c0, 1);
    index_i = 1'b0;
    cycles(6);
    chk("R7 no irq on falling edge", irq_cnt - c0, 1);
  endtask

  task automatic t_startup();
    irq_cnt = 0;
    ph = 2;
    do_reset(2'b11, 1'b1);
    chk("R9 no count from reset levels", pos_o, 0);
    chk("R9 no err from reset levels", err_o, 0);
    chk("R9 no irq from reset levels", irq_cnt, 0);
    move(1'b1, 1);
    chk("R9 first real step counts", pos_o, 1);
  endtask

  initial begin
    rst_n = 1'b0;
    phase_a_i = 1'b0; phase_b_i = 1'b0; index_i = 1'b0;
    wr_en_i = 1'b0; wr_data_i = '0; err_clr_i = 1'b0;
    t_reset();
    t_latency();
    t_count_up();
    t_count_down();
    t_wrap_up();
    t_clash();
    t_clash_vs_clear();
    t_write_vs_count();
    t_index();
    t_startup();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule